// File: doc/BRIEF.md
# Two-Wire Slave Command Decoder

This block is the bus-facing front end of a small nonvolatile-memory slave on a two-wire serial bus. It runs on a fast system clock and samples the bus clock (SCL) and data (SDA) lines. It finds start and stop conditions and shifts in the slave address byte. It accepts the byte when the three device-address bits match its strap pins and the type code selects either the memory array or the protection register. It acknowledges by pulling the open-drain SDA low and shifts out read data the same way. The storage array, the write-cycle timer and analog glitch filtering sit outside this block.

Toward the array, the block gives a word pointer and one strobe for each received write byte. The array keeps those bytes pending. A command strobe follows at the stop condition and says whether to commit a byte write, a page write or a protection-register write. Read commands are announced with the same strobe, and read bytes are taken from `rd_data_i` at the pointer. While the external write timer reports busy, the block answers no address. A master can therefore poll on the acknowledge bit.

Top module: `twi_cmd_front`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Until a start is seen, bus activity is ignored and `sda_pull_o` stays 0. After reset, `sda_pull_o`, `cmd_stb_o`, `byte_stb_o` and `active_o` are 0.
- R2: The first byte after a start is read MSB first. Bits [7:4] hold the type code, bits [3:1] hold A2..A0, and bit 0 is R/W (0 = write, 1 = read). The byte is acknowledged only when all of these hold: bits [3:1] equal `strap_i`; the type code is 1010 (memory, either direction) or 0110 (protection register, write only). Otherwise the block stays silent until the next start or stop.
- R3: SDA is sampled on the rising edge of SCL. `sda_pull_o` changes only while SCL is low, after a falling edge.
- R4: The block pulls SDA low during the ninth clock for an accepted address byte. In write mode it does the same for every later received byte.
- R5: While `busy_i` is 1, an address byte is not acknowledged, no strobe is issued, and the word pointer is unchanged.
- R6: In memory write mode, each received data byte gives a one-cycle `byte_stb_o`, with the byte on `byte_data_o` and its address on `addr_o`. The first data byte goes to the received word address. Each later byte increments only the low 4 address bits, which wrap, while the upper 4 bits stay fixed.
- R7: A memory write is committed only by a stop that follows at least one received data byte. The stop gives `cmd_stb_o` with `cmd_kind_o` = 1 (one byte) or 2 (more than one), and `cmd_addr_o` = the last written address. A start followed by a stop during address input gives no strobe. A write cut off by a repeated start gives no commit strobe.
- R8: A write to type 0110 (slave address, one ignored word byte, one data byte, stop) gives `cmd_stb_o` with `cmd_kind_o` = 5 and `cmd_addr_o` = the unchanged pointer. No `byte_stb_o` is issued.
- R9: A read address gives `cmd_stb_o` at its acknowledge, with `cmd_kind_o` = 4 (random read) if it follows a word address in the same transfer without a stop, else 3 (current read), and `cmd_addr_o` = the pointer. Read bytes come from `rd_data_i` at `addr_o`, MSB first. After each byte is loaded, the pointer increments and wraps from 255 to 0.
- R10: After a read byte, a low master acknowledge makes the block send the next byte. A high one makes it release SDA and ignore clocks until a start or stop.
- R11: After a memory write, the pointer stays at the last written address, so a current read returns that byte.
- R12: `active_o` is 1 from the end of an accepted address acknowledge until the next start, stop or refused master acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Device-address straps A2..A0 |
| busy_i | input | 1 | External write cycle in progress |
| rd_data_i | input | 8 | Array data at `addr_o` |
| sda_pull_o | output | 1 | 1 = pull SDA low |
| addr_o | output | 8 | Word pointer / write byte address |
| byte_stb_o | output | 1 | One-cycle pulse per received write byte |
| byte_data_o | output | 8 | Received write byte |
| cmd_stb_o | output | 1 | One-cycle command pulse |
| cmd_kind_o | output | 3 | 1 byte write, 2 page write, 3 current read, 4 random read, 5 protect write |
| cmd_addr_o | output | 8 | Address belonging to the command |
| active_o | output | 1 | Transfer accepted and in progress |

## Verification
Every bus edge passes through two synchroniser flops and an edge register, so an action decided on an SCL or SDA edge reaches the outputs three system clocks later. The commit strobe therefore follows a stop by three clocks. An acknowledge or data bit appears three clocks after the falling SCL edge. The bench master changes SDA four clocks after each falling edge and samples it four clocks after each rising edge, so every result has settled before it is read. Command strobes are compared on each falling clock edge against a queue of expected commands that the bench model fills before each transfer. Read data is checked against a behavioural copy of the memory.

// File: rtl/twi_cmd_front.sv
module twi_cmd_front #(
  parameter int PW = 4,
  parameter logic [3:0] MEM_TYPE = 4'b1010,
  parameter logic [3:0] PROT_TYPE = 4'b0110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       busy_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_pull_o,
  output logic [7:0] addr_o,
  output logic       byte_stb_o,
  output logic [7:0] byte_data_o,
  output logic       cmd_stb_o,
  output logic [2:0] cmd_kind_o,
  output logic [7:0] cmd_addr_o,
  output logic       active_o
);
  localparam logic [2:0] K_BYTE = 3'd1, K_PAGE = 3'd2, K_CUR = 3'd3, K_RND = 3'd4, K_PROT = 3'd5;
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WADR, S_WDAT, S_RDAT, S_WAIT} st_t;

  logic [1:0] scl_s, sda_s;
  logic       scl_q, sda_q;
  st_t        st;
  logic [3:0] bitc;
  logic [7:0] sr, tx, ptr;
  logic [1:0] nb;
  logic       prot, dummy, mack;

  wire scl_r     = scl_s[1];
  wire sda_r     = sda_s[1];
  wire scl_rise  = scl_r & ~scl_q;
  wire scl_fall  = ~scl_r & scl_q;
  wire start_det = scl_r & scl_q & sda_q & ~sda_r;
  wire stop_det  = scl_r & scl_q & ~sda_q & sda_r;
  wire is_prot   = sr[7:4] == PROT_TYPE;
  wire accept    = (sr[3:1] == strap_i) && !busy_i &&
                   ((sr[7:4] == MEM_TYPE) || (is_prot && !sr[0]));
  wire [7:0] wnext = (nb == 2'd0) ? ptr : {ptr[7:PW], ptr[PW-1:0] + 1'b1};

  assign addr_o      = ptr;
  assign byte_data_o = sr;
  assign active_o    = (st == S_WADR) || (st == S_WDAT) || (st == S_RDAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_s <= 2'b11; sda_s <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
      st <= S_IDLE; bitc <= '0; sr <= '0; tx <= '0; ptr <= '0; nb <= '0;
      prot <= 1'b0; dummy <= 1'b0; mack <= 1'b1; sda_pull_o <= 1'b0;
      byte_stb_o <= 1'b0; cmd_stb_o <= 1'b0; cmd_kind_o <= '0; cmd_addr_o <= '0;
    end else begin
      scl_s <= {scl_s[0], scl_i}; sda_s <= {sda_s[0], sda_i};
      scl_q <= scl_r; sda_q <= sda_r;
      byte_stb_o <= 1'b0; cmd_stb_o <= 1'b0;
      if (start_det) begin
        st <= S_ADDR; bitc <= '0; nb <= '0; sda_pull_o <= 1'b0;
      end else if (stop_det) begin
        if (st == S_WDAT && nb != 2'd0) begin
          cmd_stb_o  <= 1'b1;
          cmd_kind_o <= prot ? K_PROT : (nb == 2'd1 ? K_BYTE : K_PAGE);
          cmd_addr_o <= ptr;
        end
        st <= S_IDLE; dummy <= 1'b0; sda_pull_o <= 1'b0;
      end else if (st != S_IDLE && st != S_WAIT) begin
        if (scl_rise) begin
          if (bitc < 4'd8) sr <= {sr[6:0], sda_r};
          if (bitc == 4'd8) mack <= sda_r;
          if (bitc != 4'd9) bitc <= bitc + 4'd1;
        end else if (scl_fall) begin
          if (bitc == 4'd8) begin
            case (st)
              S_ADDR: if (accept) begin
                sda_pull_o <= 1'b1; prot <= is_prot;
                if (sr[0]) begin
                  tx <= rd_data_i; ptr <= ptr + 8'd1; dummy <= 1'b0;
                  cmd_stb_o <= 1'b1; cmd_kind_o <= dummy ? K_RND : K_CUR; cmd_addr_o <= ptr;
                end
              end else st <= S_WAIT;
              S_WADR: begin
                sda_pull_o <= 1'b1; dummy <= !prot;
                if (!prot) ptr <= sr;
              end
              S_WDAT: begin
                sda_pull_o <= 1'b1; dummy <= 1'b0;
                nb <= (nb == 2'd2) ? nb : nb + 2'd1;
                if (!prot) begin ptr <= wnext; byte_stb_o <= 1'b1; end
              end
              default: sda_pull_o <= 1'b0;
            endcase
          end else if (bitc == 4'd9) begin
            bitc <= '0;
            case (st)
              S_ADDR: begin st <= sr[0] ? S_RDAT : S_WADR; sda_pull_o <= sr[0] & ~tx[7]; end
              S_WADR: begin st <= S_WDAT; sda_pull_o <= 1'b0; end
              S_RDAT: if (!mack) begin
                tx <= rd_data_i; ptr <= ptr + 8'd1; sda_pull_o <= ~rd_data_i[7];
              end else begin
                st <= S_WAIT; sda_pull_o <= 1'b0;
              end
              default: sda_pull_o <= 1'b0;
            endcase
          end else if (st == S_RDAT && bitc != 4'd0) begin
            sda_pull_o <= ~tx[6]; tx <= {tx[6:0], 1'b0};
          end
        end
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_pull_o); // R1
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !scl_r); // R3
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && bitc == 4'd8 && scl_fall && !start_det && !stop_det && busy_i) |=> (!sda_pull_o && !cmd_stb_o)); // R5
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_stb_o, byte_stb_o})); // R6
  AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb_o && (cmd_kind_o == K_BYTE || cmd_kind_o == K_PAGE || cmd_kind_o == K_PROT)) |-> $past(stop_det)); // R7
endmodule

// File: tb/twi_cmd_front_tb.sv
module twi_cmd_front_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sdm = 1'b0;
  logic [2:0] strap = 3'b101;
  logic [7:0] arr [256];
  logic [7:0] ref_mem [256];
  logic [7:0] ref_ptr = 8'd0;
  logic [15:0] pend [$];
  int exp_q [$];
  int bcnt = 0;
  int checks = 0, errors = 0, r3_viol = 0;
  logic sda_pull, byte_stb, cmd_stb, active, act_q = 1'b0, pull_q = 1'b0;
  logic [7:0] addr, bdata, caddr;
  logic [2:0] ckind;
  wire sda_line = !(sdm | sda_pull);
  wire busy = bcnt != 0;
  localparam logic [7:0] AW = 8'hAA, AR = 8'hAB;

  always #5 clk = ~clk;

  twi_cmd_front u_dut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap_i(strap),
    .busy_i(busy), .rd_data_i(arr[addr]), .sda_pull_o(sda_pull), .addr_o(addr),
    .byte_stb_o(byte_stb), .byte_data_o(bdata), .cmd_stb_o(cmd_stb), .cmd_kind_o(ckind),
    .cmd_addr_o(caddr), .active_o(active));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // array and write-timer stub
  always @(posedge clk) begin
    act_q <= active;
    if (bcnt != 0) bcnt <= bcnt - 1;
    if (byte_stb) pend.push_back({addr, bdata});
    if (cmd_stb && (ckind == 3'd1 || ckind == 3'd2)) begin
      foreach (pend[i]) arr[pend[i][15:8]] <= pend[i][7:0];
      pend.delete();
    end else if (act_q && !active) pend.delete();
    if (cmd_stb && (ckind == 3'd1 || ckind == 3'd2 || ckind == 3'd5)) bcnt <= 400;
  end

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n) begin
    pull_q <= sda_pull;
    if (sda_pull != pull_q && scl_m) r3_viol++;
    if (cmd_stb) begin
      if (exp_q.size() == 0) chk("R7 unexpected command strobe", {ckind, caddr}, 0);
      else chk("R7/R9 command kind/address", {ckind, caddr}, exp_q.pop_front());
    end
  end

  task automatic tick(int n); repeat (n) @(posedge clk); #1; endtask
  task automatic bus_start; sdm = 0; tick(4); scl_m = 1; tick(8); sdm = 1; tick(8); scl_m = 0; tick(4); endtask
  task automatic bus_stop; sdm = 1; tick(4); scl_m = 1; tick(8); sdm = 0; tick(8); endtask
  task automatic put_bit(logic b); sdm = !b; tick(4); scl_m = 1; tick(8); scl_m = 0; tick(4); endtask
  task automatic get_bit(output logic b); sdm = 0; tick(4); scl_m = 1; tick(4); b = sda_line; tick(4); scl_m = 0; tick(4); endtask
  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(ack);
  endtask
  task automatic recv_byte(logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(mack);
  endtask
  task automatic exp_cmd(int kind, logic [7:0] a); exp_q.push_back({kind[2:0], a}); endtask
  task automatic wait_idle; while (busy) tick(1); tick(20); endtask

  task automatic mem_write(logic [7:0] wa, logic [7:0] d[$], string req);
    logic ack; logic [7:0] a;
    bus_start; send_byte(AW, ack); chk({req, " address ack"}, ack, 0);
    send_byte(wa, ack); chk({req, " word ack"}, ack, 0);
    a = wa;
    foreach (d[i]) begin
      if (i != 0) a = {a[7:4], a[3:0] + 4'd1};
      ref_mem[a] = d[i];
      send_byte(d[i], ack); chk({req, " data ack R4"}, ack, 0);
    end
    ref_ptr = a;
    exp_cmd(d.size() == 1 ? 1 : 2, a);
    bus_stop;
  endtask

  task automatic rand_read(logic [7:0] wa, int n, string req);
    logic ack; logic [7:0] d;
    bus_start; send_byte(AW, ack); send_byte(wa, ack);
    bus_start; exp_cmd(4, wa); send_byte(AR, ack); chk({req, " read address ack"}, ack, 0);
    ref_ptr = wa;
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, d);
      chk({req, " read data"}, d, ref_mem[ref_ptr]);
      ref_ptr = ref_ptr + 8'd1;
    end
    bus_stop;
  endtask

  initial begin
    logic ack; logic [7:0] d;
    for (int i = 0; i < 256; i++) begin arr[i] = 8'hFF; ref_mem[i] = 8'hFF; end
    tick(10); rst_n = 1; tick(2);
    chk("R1 reset pull", sda_pull, 0); chk("R1 reset cmd", cmd_stb, 0);
    chk("R1 reset byte strobe", byte_stb, 0); chk("R12 reset active", active, 0);

    scl_m = 0; tick(4); send_byte(AW, ack); chk("R1 no ack without start", ack, 1); bus_stop;

    mem_write(8'h25, '{8'hA5}, "R6 byte write");
    bus_start; send_byte(AW, ack); chk("R5 no ack while busy", ack, 1);
    chk("R5 busy still set", busy, 1); bus_stop;
    wait_idle;

    mem_write(8'h3E, '{8'h11, 8'h22, 8'h33, 8'h44}, "R6 page write");
    wait_idle;
    bus_start; exp_cmd(3, ref_ptr); send_byte(AR, ack); chk("R2 read ack", ack, 0);
    chk("R12 active during read", active, 1);
    recv_byte(1, d); chk("R11 current read after page write", d, 8'h44);
    ref_ptr = ref_ptr + 8'd1;
    for (int i = 0; i < 9; i++) begin get_bit(ack); chk("R10 silent after master nack", ack, 1); end
    chk("R12 inactive after nack", active, 0);
    bus_stop;

    rand_read(8'h3E, 3, "R6/R9 page wrap");
    rand_read(8'h30, 2, "R9 random read");
    bus_start; exp_cmd(3, ref_ptr); send_byte(AR, ack);
    recv_byte(1, d); chk("R9 current read follows pointer", d, ref_mem[ref_ptr]);
    ref_ptr = ref_ptr + 8'd1; bus_stop;

    mem_write(8'h00, '{8'h5A}, "R7 byte write low");
    wait_idle;
    rand_read(8'hFF, 2, "R9 pointer wrap");

    bus_start; send_byte(8'hA0, ack); chk("R2 strap mismatch", ack, 1); bus_stop;
    bus_start; send_byte(8'hBA, ack); chk("R2 wrong type", ack, 1); bus_stop;
    bus_start; send_byte(8'h6B, ack); chk("R2 protect read refused", ack, 1); bus_stop;

    bus_start; send_byte(8'h6A, ack); chk("R8 protect address ack", ack, 0);
    send_byte(8'h00, ack); send_byte(8'h00, ack); chk("R8 protect data ack", ack, 0);
    exp_cmd(5, ref_ptr); bus_stop;
    wait_idle;

    bus_start; for (int i = 7; i >= 4; i--) put_bit(AW[i]); bus_stop; tick(10);
    chk("R7 start-stop cancel leaves no strobe", exp_q.size(), 0);

    bus_start; send_byte(AW, ack); send_byte(8'h50, ack); send_byte(8'h77, ack);
    chk("R4 data ack before abort", ack, 0);
    rand_read(8'h50, 1, "R7 aborted write not committed");

    tick(50);
    chk("R3 drive changes only with SCL low", r3_viol, 0);
    chk("R7 all expected commands seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule